// File: doc/BRIEF.md
# NAND Flash Host Port with Hamming Parity Engine

This block connects a simple byte-wide CPU register bus to an 8-bit raw NAND flash device. Software moves bytes to and from the flash through one data-port register. It drives the command-latch, address-latch, two active-low chip-select pins and the active-low write-protect pin through a control register. The same register shows the flash ready/busy line. Software sends command sequences, handles flash timing and corrects errors. The block only produces one write or read strobe on the flash pins for each data-port access.

Each byte that passes through the data port, in either direction, is also fed into a Hamming parity engine. Over a 256-byte chunk the engine builds 16 line-parity bits and 6 column-parity bits, which together locate one flipped bit. It also counts the bytes fed so far. Software clears the engine before a chunk, moves 256 bytes and then reads the raw parity. It inverts the parity and packs it into three code bytes, with the column parity in bits 7:2 of the third byte and bits 1:0 forced to 1. A nonzero byte count at that point means the chunk is incomplete.

Register byte offsets:

| Offset | Register |
| --- | --- |
| 0x00 | line parity, low byte |
| 0x04 | line parity, high byte |
| 0x08 | column parity in bits 5:0 |
| 0x0C | byte count |
| 0x10 | ECC clear |
| 0x14 | flash data port |
| 0x18 | flash control |

Bus requests must be at least two clock cycles apart.

Top module: `nand_host_ecc`

## Requirements
- R1: After reset, fl_ce_n is 2'b11, fl_cle and fl_ale are 0, fl_wp_n is 0, fl_we_n and fl_re_n are 1, fl_io_oe is 0, and the byte count and both parities are 0. The control register then reads {2'b00, ready, 5'b10001}.
- R2: A write to the control register (offset 0x18) takes effect on the next clock edge, as follows:
  - bit 0 drives fl_ce_n[0];
  - bit 1 drives fl_cle;
  - bit 2 drives fl_ale;
  - bit 3 drives fl_wp_n;
  - bit 4 drives fl_ce_n[1];
  - written bits 7:5 are ignored.

  A read of the control register returns these five bits in the same positions.
- R3: Control register bit 5 reads the fl_rdy pin after a two-flop synchronizer. Bits 7:6 read 0.
- R4: A write to the data port (offset 0x14) places the byte on fl_io_out and sets fl_io_oe. It drives fl_we_n low for exactly the one cycle after the request, while fl_re_n stays high.
- R5: A read of the data port drives fl_re_n low for exactly the one cycle after the request. It captures fl_io_in at the end of that cycle, returns the byte on bus_rdata and clears fl_io_oe.
- R6: Every data-port byte, read or written, adds one to the 8-bit byte count. The count wraps to 0 after the 256th byte.
- R7: Line parity bits 2k and 2k+1, for k = 0..7, are computed from the byte parities (XOR of all 8 bits of each byte). Bit 2k is the XOR of the byte parities of all fed bytes whose byte-count value at feed time had bit k = 0. Bit 2k+1 covers those with bit k = 1. Offset 0x00 holds bits 7:0 and 0x04 holds bits 15:8.
- R8: Column parity bits 2j and 2j+1, for j = 0..2, are computed over all fed bytes. Bit 2j is the XOR of the data bits whose bit index has bit j = 0. Bit 2j+1 covers the data bits whose index has bit j = 1.
- R9: Any write to offset 0x10 clears the byte count and both parities, whatever the data. Reading 0x10 returns 0.
- R10: bus_rdata changes on the second clock edge after a read request and then holds until the next read completes. Reading a register other than the data port does not change the parity engine.
- R11: A write to any unmapped offset changes no register or pin, and a read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write request, one cycle |
| bus_rd | input | 1 | Read request, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid two edges after the request |
| fl_io_out | output | 8 | Byte driven toward the flash |
| fl_io_oe | output | 1 | Output enable for fl_io_out |
| fl_io_in | input | 8 | Byte from the flash |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_ce_n | output | 2 | Active-low chip enables |
| fl_wp_n | output | 1 | Active-low write protect |
| fl_we_n | output | 1 | Active-low write strobe |
| fl_re_n | output | 1 | Active-low read strobe |
| fl_rdy | input | 1 | Flash ready/busy, high when ready |

## Verification
The bench builds the block with its default chunk address width of 8 and a two-stage ready synchronizer. These values bring the exact 256-byte wrap of the byte count and the 16-bit line parity within reach of a full chunk of mixed random reads and writes.

With the short synchronizer, the ready bit can be checked a few cycles after the pin changes. Directed cases add:
- a single byte at chunk position 0, with a known parity pattern;
- control writes with the upper bits set;
- unmapped offsets;
- a clear after a partial chunk.

// File: rtl/nand_host_pkg.sv
// Package: register offsets and control-bit positions shared by the
// NAND host port, its submodules and its checker.
package nand_host_pkg;
    localparam int BYTE_W   = 8;
    localparam int CHUNK_AW = 8;

    localparam int OFS_LP_LO = 'h00;
    localparam int OFS_LP_HI = 'h04;
    localparam int OFS_CP    = 'h08;
    localparam int OFS_CNT   = 'h0C;
    localparam int OFS_CLR   = 'h10;
    localparam int OFS_DATA  = 'h14;
    localparam int OFS_CTRL  = 'h18;

    localparam int CB_CE0 = 0;
    localparam int CB_CLE = 1;
    localparam int CB_ALE = 2;
    localparam int CB_WP  = 3;
    localparam int CB_CE1 = 4;
    localparam int CB_RDY = 5;

    localparam int CTRL_W = 5;
    localparam logic [CTRL_W-1:0] CTRL_RST = 5'b10001;

    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/nand_rdy_sync.sv
// nand_rdy_sync: brings the asynchronous ready/busy pin into the clock
// domain through a shift chain of STAGES flops.
// Assumes STAGES >= 2.
module nand_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic synced
);
    logic [STAGES-1:0] chain;

    // shift the pin value through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin};
    end

    assign synced = chain[STAGES-1];
endmodule

// File: rtl/nand_ecc_acc.sv
// nand_ecc_acc: Hamming parity accumulator.
// Each byte it is fed updates the line parity, using the current byte
// count as the byte's position in the chunk, and the column parity,
// using each data bit's index. It then advances the count.
// A clear takes priority over a feed in the same cycle.
// Assumes BYTE_W is a power of two.
module nand_ecc_acc
    import nand_host_pkg::*;
#(
    parameter int AW    = CHUNK_AW,
    parameter int DW    = BYTE_W,
    localparam int LP_W = 2 * AW,
    localparam int BA_W = $clog2(DW),
    localparam int CP_W = 2 * BA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            feed,
    input  logic [DW-1:0]   feed_byte,
    output logic [LP_W-1:0] lp,
    output logic [CP_W-1:0] cp,
    output logic [AW-1:0]   cnt
);
    logic [LP_W-1:0] lp_tog;
    logic [CP_W-1:0] cp_tog;
    logic            byte_par;

    // compute which parity bits this byte toggles
    always_comb begin
        byte_par = ^feed_byte;
        for (int k = 0; k < AW; k++) begin
            lp_tog[2*k]   = byte_par & ~cnt[k];
            lp_tog[2*k+1] = byte_par &  cnt[k];
        end
        for (int j = 0; j < BA_W; j++) begin
            cp_tog[2*j]   = 1'b0;
            cp_tog[2*j+1] = 1'b0;
            for (int b = 0; b < DW; b++) begin
                if (((b >> j) & 1) == 1) cp_tog[2*j+1] = cp_tog[2*j+1] ^ feed_byte[b];
                else                     cp_tog[2*j]   = cp_tog[2*j]   ^ feed_byte[b];
            end
        end
    end

    // accumulate parity and byte count, or clear on request
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lp  <= '0;
            cp  <= '0;
            cnt <= '0;
        end else if (feed) begin
            lp  <= lp ^ lp_tog;
            cp  <= cp ^ cp_tog;
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/nand_pin_ctrl.sv
// nand_pin_ctrl: holds the control bits that drive the flash pins
// directly, and makes the one-cycle write and read strobes for
// data-port accesses.
// Assumes requests are spaced at least two cycles apart.
module nand_pin_ctrl
    import nand_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              dp_wr,
    input  logic              dp_rd,
    input  byte_t             dp_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output byte_t             io_out,
    output logic              io_oe,
    output logic              we_n,
    output logic              re_n
);
    // control register: written bits drive the pins as they are
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= CTRL_RST;
        else if (ctrl_we) ctrl_q <= ctrl_wdata;
    end

    // strobes: low for the one cycle after a data-port request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_n <= 1'b1;
            re_n <= 1'b1;
        end else begin
            we_n <= ~dp_wr;
            re_n <= ~dp_rd;
        end
    end

    // output data and its enable: set by a write, released by a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_out <= '0;
            io_oe  <= 1'b0;
        end else if (dp_wr) begin
            io_out <= dp_wdata;
            io_oe  <= 1'b1;
        end else if (dp_rd) begin
            io_oe  <= 1'b0;
        end
    end
endmodule

// File: rtl/nand_host_ecc.sv
// nand_host_ecc: register-bus port to an 8-bit raw NAND flash, with a
// Hamming parity engine fed by every data-port byte.
// Reads return two clock edges after the request. Bus requests must be
// at least two cycles apart.
module nand_host_ecc
    import nand_host_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [7:0]        fl_io_out,
    output logic              fl_io_oe,
    input  logic [7:0]        fl_io_in,
    output logic              fl_cle,
    output logic              fl_ale,
    output logic [1:0]        fl_ce_n,
    output logic              fl_wp_n,
    output logic              fl_we_n,
    output logic              fl_re_n,
    input  logic              fl_rdy
);
    localparam int LP_W = 2 * CHUNK_AW;
    localparam int CP_W = 2 * $clog2(BYTE_W);

    logic              sel_data;
    logic              sel_ctrl;
    logic              sel_clr;
    logic              rd_pend;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_done_dp;
    logic              feed;
    byte_t             feed_byte;
    logic [CTRL_W-1:0] ctrl_q;
    logic              rdy_s;
    logic [LP_W-1:0]   ecc_lp;
    logic [CP_W-1:0]   ecc_cp;
    logic [CHUNK_AW-1:0] ecc_cnt;
    byte_t             rd_mux;

    assign sel_data = (bus_addr == ADDR_W'(OFS_DATA));
    assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign sel_clr  = (bus_addr == ADDR_W'(OFS_CLR));

    // remember a read request until its data is taken one edge later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            rd_addr <= '0;
        end else begin
            rd_pend <= bus_rd;
            if (bus_rd) rd_addr <= bus_addr;
        end
    end

    assign rd_done_dp = rd_pend && (rd_addr == ADDR_W'(OFS_DATA));

    // the parity engine takes write data at once and read data at capture
    always_comb begin
        feed      = (bus_wr && sel_data) || rd_done_dp;
        feed_byte = (bus_wr && sel_data) ? bus_wdata : fl_io_in;
    end

    nand_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (fl_rdy),
        .synced (rdy_s)
    );

    nand_pin_ctrl u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (bus_wr && sel_ctrl),
        .ctrl_wdata (bus_wdata[CTRL_W-1:0]),
        .dp_wr      (bus_wr && sel_data),
        .dp_rd      (bus_rd && sel_data),
        .dp_wdata   (bus_wdata),
        .ctrl_q     (ctrl_q),
        .io_out     (fl_io_out),
        .io_oe      (fl_io_oe),
        .we_n       (fl_we_n),
        .re_n       (fl_re_n)
    );

    nand_ecc_acc u_ecc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (bus_wr && sel_clr),
        .feed      (feed),
        .feed_byte (feed_byte),
        .lp        (ecc_lp),
        .cp        (ecc_cp),
        .cnt       (ecc_cnt)
    );

    assign fl_ce_n = {ctrl_q[CB_CE1], ctrl_q[CB_CE0]};
    assign fl_cle  = ctrl_q[CB_CLE];
    assign fl_ale  = ctrl_q[CB_ALE];
    assign fl_wp_n = ctrl_q[CB_WP];

    // select the byte a completed read returns
    always_comb begin
        case (int'(rd_addr))
            OFS_LP_LO: rd_mux = ecc_lp[7:0];
            OFS_LP_HI: rd_mux = ecc_lp[15:8];
            OFS_CP:    rd_mux = byte_t'(ecc_cp);
            OFS_CNT:   rd_mux = ecc_cnt;
            OFS_DATA:  rd_mux = fl_io_in;
            OFS_CTRL:  rd_mux = {2'b00, rdy_s, ctrl_q};
            default:   rd_mux = '0;
        endcase
    end

    // read data register: loaded when a read completes, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)       bus_rdata <= '0;
        else if (rd_pend) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/nand_host_ecc_chk.sv
// nand_host_ecc_chk: protocol and parity-engine properties of the NAND
// host port, attached to the top module by bind.
module nand_host_ecc_chk
    import nand_host_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              fl_we_n,
    input logic              fl_re_n,
    input logic [1:0]        fl_ce_n,
    input logic              fl_cle,
    input logic              fl_ale,
    input logic              fl_wp_n,
    input logic [7:0]        ecc_cnt,
    input logic [15:0]       ecc_lp,
    input logic [5:0]        ecc_cp
);
    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_re_n)); // R4

    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |=> fl_we_n); // R4

    AST_WE_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_DATA)) |=> !fl_we_n); // R4

    AST_RE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_re_n |=> fl_re_n); // R5

    AST_RE_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFS_DATA)) |=> !fl_re_n); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_DATA)) |=> ecc_cnt == 8'($past(ecc_cnt) + 8'd1)); // R6

    AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_CLR)) |=> (ecc_cnt == 8'd0 && ecc_lp == 16'd0 && ecc_cp == 6'd0)); // R9

    AST_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(OFS_CTRL)) |=> $stable({fl_ce_n, fl_cle, fl_ale, fl_wp_n})); // R2
endmodule

bind nand_host_ecc nand_host_ecc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .fl_we_n  (fl_we_n),
    .fl_re_n  (fl_re_n),
    .fl_ce_n  (fl_ce_n),
    .fl_cle   (fl_cle),
    .fl_ale   (fl_ale),
    .fl_wp_n  (fl_wp_n),
    .ecc_cnt  (ecc_cnt),
    .ecc_lp   (ecc_lp),
    .ecc_cp   (ecc_cp)
);

// File: tb/nand_host_ecc_tb.sv
// nand_host_ecc_tb: random data traffic plus directed corner cases,
// checked against a parity model kept in the bench.
module nand_host_ecc_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] fl_io_out;
    logic       fl_io_oe;
    logic [7:0] fl_io_in = '0;
    logic       fl_cle, fl_ale, fl_wp_n, fl_we_n, fl_re_n;
    logic [1:0] fl_ce_n;
    logic       fl_rdy = 1'b0;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [7:0]  m_cnt = '0;
    logic [15:0] m_lp  = '0;
    logic [5:0]  m_cp  = '0;

    always #10 clk = ~clk;

    nand_host_ecc u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe), .fl_io_in(fl_io_in),
        .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_ce_n(fl_ce_n), .fl_wp_n(fl_wp_n),
        .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_rdy(fl_rdy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // bench parity model, written from the R6-R8 definitions
    function automatic void model_byte(input logic [7:0] d);
        logic p;
        p = ^d;
        for (int k = 0; k < 8; k++)
            if (p) begin
                if (m_cnt[k]) m_lp[2*k+1] = ~m_lp[2*k+1];
                else          m_lp[2*k]   = ~m_lp[2*k];
            end
        for (int b = 0; b < 8; b++)
            for (int j = 0; j < 3; j++)
                if (d[b]) begin
                    if (b[j]) m_cp[2*j+1] = ~m_cp[2*j+1];
                    else      m_cp[2*j]   = ~m_cp[2*j];
                end
        m_cnt = m_cnt + 8'd1;
    endfunction

    function automatic void model_clear();
        m_cnt = '0; m_lp = '0; m_cp = '0;
    endfunction

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        @(negedge clk); d = bus_rdata;
    endtask

    // data-port write with strobe checks (R4)
    task automatic dp_write(input logic [7:0] d, input bit chk);
        @(negedge clk); bus_addr = 5'h14; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        if (chk) begin
            check("R4 we_n low", fl_we_n, 1'b0);
            check("R4 re_n high", fl_re_n, 1'b1);
            check("R4 io_out", fl_io_out, d);
            check("R4 io_oe", fl_io_oe, 1'b1);
        end
        @(negedge clk);
        if (chk) check("R4 we_n released", fl_we_n, 1'b1);
        model_byte(d);
    endtask

    // data-port read with strobe checks (R5, R10)
    task automatic dp_read(input logic [7:0] flash_val, input bit chk);
        @(negedge clk); bus_addr = 5'h14; bus_rd = 1'b1; fl_io_in = flash_val;
        @(negedge clk); bus_rd = 1'b0;
        if (chk) begin
            check("R5 re_n low", fl_re_n, 1'b0);
            check("R5 we_n high", fl_we_n, 1'b1);
        end
        @(negedge clk);
        fl_io_in = ~flash_val;
        if (chk) begin
            check("R5 rdata", bus_rdata, flash_val);
            check("R5 re_n released", fl_re_n, 1'b1);
            check("R5 io_oe cleared", fl_io_oe, 1'b0);
        end
        model_byte(flash_val);
    endtask

    task automatic check_ecc(input string tag);
        logic [7:0] lo, hi, c, n;
        bus_read(5'h00, lo);
        bus_read(5'h04, hi);
        bus_read(5'h08, c);
        bus_read(5'h0C, n);
        check({tag, " R7 line parity"}, {hi, lo}, m_lp);
        check({tag, " R8 column parity"}, c, {2'b00, m_cp});
        check({tag, " R6 byte count"}, n, m_cnt);
    endtask

    initial begin
        logic [7:0] rv;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 ce_n", fl_ce_n, 2'b11);
        check("R1 cle/ale", {fl_cle, fl_ale}, 2'b00);
        check("R1 wp_n", fl_wp_n, 1'b0);
        check("R1 strobes", {fl_we_n, fl_re_n}, 2'b11);
        check("R1 io_oe", fl_io_oe, 1'b0);
        bus_read(5'h18, rv);
        check("R1 ctrl read", rv, 8'h11);
        check_ecc("R1");

        // R2: control bits drive pins; upper written bits ignored
        bus_write(5'h18, 8'hEE);
        check("R2 ce_n", fl_ce_n, 2'b00);
        check("R2 cle", fl_cle, 1'b1);
        check("R2 ale", fl_ale, 1'b1);
        check("R2 wp_n", fl_wp_n, 1'b1);
        bus_read(5'h18, rv);
        check("R2 ctrl readback", rv, 8'h0E);
        bus_write(5'h18, 8'h19);
        check("R2 pins second", {fl_ce_n, fl_cle, fl_ale, fl_wp_n}, {2'b11, 1'b0, 1'b0, 1'b1});

        // R3: synchronized ready bit
        fl_rdy = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(5'h18, rv);
        check("R3 ready high", rv, 8'h39);
        fl_rdy = 1'b0;
        repeat (4) @(negedge clk);
        bus_read(5'h18, rv);
        check("R3 ready low", rv, 8'h19);

        // R7/R8 directed: one byte 0x01 at chunk position 0
        bus_write(5'h10, 8'h00);
        model_clear();
        dp_write(8'h01, 1'b1);
        check_ecc("R7 single");
        check("R7 single lp pattern", m_lp, 16'h5555);
        check("R8 single cp pattern", m_cp, 6'h15);

        // R9: clear after partial chunk, with nonzero data
        dp_write(8'hA7, 1'b0);
        dp_read(8'h3C, 1'b1);
        bus_write(5'h10, 8'h5A);
        model_clear();
        check_ecc("R9 clear");
        bus_read(5'h10, rv);
        check("R9 clear reads zero", rv, 8'h00);

        // R6-R8: full random chunk of mixed reads and writes, count wraps
        for (int i = 0; i < 256; i++) begin
            if ($urandom_range(0, 2) == 0) dp_read(8'($urandom), i < 4);
            else                           dp_write(8'($urandom), i < 4);
        end
        check_ecc("R6 full chunk");
        check("R6 wrapped to zero", m_cnt, 8'h00);

        // R10: register reads leave the engine unchanged, rdata holds
        check_ecc("R10 reread");
        bus_read(5'h0C, rv);
        repeat (5) @(negedge clk);
        check("R10 rdata holds", bus_rdata, rv);

        // partial random chunk
        for (int i = 0; i < 37; i++) dp_write(8'($urandom), 1'b0);
        check_ecc("R6 partial");

        // R11: unmapped write no effect, unmapped read zero
        bus_write(5'h1C, 8'hFF);
        bus_write(5'h01, 8'hFF);
        check("R11 pins unchanged", {fl_ce_n, fl_cle, fl_ale, fl_wp_n, fl_we_n, fl_re_n}, {2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1});
        bus_read(5'h1C, rv);
        check("R11 unmapped read", rv, 8'h00);
        bus_read(5'h18, rv);
        check("R11 ctrl unchanged", rv, 8'h19);
        check_ecc("R11 engine unchanged");

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule